// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the receive path just after the stage that strips flags and stuffed zeros from an HDLC bit stream. It sees one byte per valid beat, marked with start-of-frame, end-of-frame and an error qualifier that is meaningful on the closing beat. The first one or two bytes of each frame form the frame address. They are assembled little-endian: the first byte is the low half, the second byte the high half. The 16-bit result is compared against a table of programmable entries under one shared per-bit mask.

Frames whose address hits any entry are passed on whole to the buffer side, address bytes included. Frames that miss are swallowed. A saturating counter records how many error-free frames were turned away. The address bytes wait in a small queue until the verdict is known, so nothing leaves the block ahead of the decision. A select input chooses single-byte or two-byte addressing. Both modes use the same comparator: in single-byte mode the upper half of the assembled address is zero, and the upper mask bits are normally cleared.

Top module: `hdlc_addr_filter`

## Requirements
- R1: A frame is accepted when its assembled address equals, under the mask, any one of the NUM_ADDR table entries. Entry k occupies bits [16k+15:16k] of `cfg_addr`.
- R2: A mask bit of 1 makes the matching address bit take part in the comparison. A mask bit of 0 makes that bit a don't-care.
- R3: In two-byte mode the first byte after the opening flag is compared with bits [7:0] of each entry and the second byte with bits [15:8]. The sequence 0x68, 0xAA hits entry 0xAA68, and the sequence 0xAA, 0x68 does not.
- R4: With `cfg_wide` = 0 the verdict is taken on the first byte alone and the upper half of the assembled address is zero. With mask 0x00FF, the upper byte of every entry is therefore ignored.
- R5: An entry of 0xFFFF under a full mask accepts frames addressed 0xFF, 0xFF, alongside a unicast entry held in another slot.
- R6: An accepted frame leaves on `out_data` with every byte in order, one byte per `out_valid` cycle. `out_sof` is set on its first byte and `out_eof` on its last byte. `out_err` is set on the last byte when the frame closed with an error, and `out_err` is never set without `out_valid` and `out_eof`.
- R7: A rejected frame produces no output byte. If it closes without error, `nomatch_cnt` rises by one in the cycle after its closing beat.
- R8: A frame that closes with `in_err` = 1 leaves `nomatch_cnt` unchanged, whether or not it hit.
- R9: In two-byte mode, a frame that closes on its first byte is a miss. It is counted only when error-free.
- R10: In two-byte mode, no byte of a frame appears at the output before its second byte has been received, however long the gap between the two bytes.
- R11: `nomatch_cnt` saturates at its all-ones value.
- R12: `cnt_clr` forces `nomatch_cnt` to zero on the next cycle, and this takes priority over a same-cycle increment. `nomatch_cnt` changes only after a closing beat or a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wide | input | 1 | 1: two-byte address, 0: single-byte address |
| cfg_mask | input | 16 | Shared comparison mask, 1 = bit compared |
| cfg_addr | input | NUM_ADDR*16 | Address table, entry k at bits [16k+15:16k] |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte after the opening flag |
| in_eof | input | 1 | Last byte before the closing flag |
| in_err | input | 1 | Frame ended in error (qualified by in_eof) |
| cnt_clr | input | 1 | Clears the rejected-frame counter |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Last byte of a forwarded frame |
| out_err | output | 1 | Forwarded frame ended in error |
| nomatch_cnt | output | CNT_W | Error-free rejected frames, saturating |

## Verification
The bench builds the filter with four table entries and a four-deep holding queue, but narrows the rejected-frame counter to 4 bits. At that width saturation is reached after fifteen missed frames, so the clamp and the priority of a clear over a same-cycle increment can both be exercised directly. Keeping the queue at its default depth means that back-to-back frames, including a rejected one between two accepted ones, load it as heavily as the design allows. Every entry slot is hit in turn, and a byte gap is held open inside the address field to confirm that nothing leaks out early.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  // Per-frame receive state of the address stage
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,  // between frames
    ST_ADDR_HI = 2'd1,  // low address byte held, waiting for the high byte
    ST_PASS    = 2'd2,  // frame accepted, bytes are forwarded
    ST_DROP    = 2'd3   // frame rejected, bytes are discarded
  } fr_state_e;

  // Qualifiers travelling with each queued byte
  typedef struct packed {
    logic sof;
    logic eof;
    logic err;
  } byte_tag_t;

  localparam int TAG_W = $bits(byte_tag_t);

endpackage

// File: rtl/hdlc_af_rst_sync.sv
module hdlc_af_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  // Assertion is immediate, release walks through the chain
  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
  parameter int NUM_ADDR = 4,
  parameter int ADDR_W   = 16
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ADDR_W-1:0]          mask,
  input  logic [NUM_ADDR*ADDR_W-1:0] table_i,
  output logic                       hit
);

  logic [NUM_ADDR-1:0] hit_vec;

  // One masked equality per table entry, OR-reduced
  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_entry
    logic [ADDR_W-1:0] diff;
    assign diff       = (addr ^ table_i[g*ADDR_W +: ADDR_W]) & mask;
    assign hit_vec[g] = (diff == '0);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/hdlc_af_fifo.sv
module hdlc_af_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          drop_tail,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d, widx;
  logic [CW-1:0] count_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH-1) : p - PW'(1);
  endfunction

  // Dropping the newest entry and pushing in the same cycle overwrites it
  always_comb begin
    widx   = drop_tail ? ptr_dec(wptr_q) : wptr_q;
    wptr_d = wptr_q;
    if (push && !drop_tail) begin
      wptr_d = ptr_inc(wptr_q);
    end else if (!push && drop_tail) begin
      wptr_d = ptr_dec(wptr_q);
    end
    rptr_d  = pop ? ptr_inc(rptr_q) : rptr_q;
    count_d = count + CW'(push) - CW'(drop_tail) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      count  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      count  <= count_d;
    end
  end

  // Storage carries no reset; occupancy is tracked by the pointers
  always_ff @(posedge clk) begin
    if (push) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[rptr_q];

endmodule

// File: rtl/hdlc_af_ctl.sv
module hdlc_af_ctl
  import hdlc_af_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int QCNT_W = 3,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int QW     = BYTE_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              hit,
  input  logic              cnt_clr,
  input  logic [QCNT_W-1:0] q_count,
  output logic [ADDR_W-1:0] addr_asm,
  output logic              q_push,
  output logic              q_drop,
  output logic [QW-1:0]     q_wdata,
  output logic              q_pop,
  output logic [CNT_W-1:0]  nomatch_cnt
);

  fr_state_e         st_q, st_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              pend_q, pend_d;
  logic              miss_end;
  logic              cnt_sat, cnt_en;
  logic [CNT_W-1:0]  cnt_d;
  byte_tag_t         wtag;

  // Assembled address: high byte only once the second byte is in hand
  always_comb begin
    if (st_q == ST_ADDR_HI && !in_sof) begin
      addr_asm = {in_data, lo_q};
    end else begin
      addr_asm = {{BYTE_W{1'b0}}, in_data};
    end
  end

  // Frame-level decision
  always_comb begin
    st_d     = st_q;
    lo_d     = lo_q;
    pend_d   = pend_q;
    q_push   = 1'b0;
    q_drop   = 1'b0;
    miss_end = 1'b0;
    if (in_valid) begin
      if (in_sof) begin
        q_drop = pend_q;          // an unfinished address is abandoned
        pend_d = 1'b0;
        if (cfg_wide && !in_eof) begin
          q_push = 1'b1;
          pend_d = 1'b1;
          lo_d   = in_data;
          st_d   = ST_ADDR_HI;
        end else if (cfg_wide) begin
          miss_end = !in_err;     // closed before the address was complete
          st_d     = ST_IDLE;
        end else if (hit) begin
          q_push = 1'b1;
          st_d   = in_eof ? ST_IDLE : ST_PASS;
        end else begin
          miss_end = in_eof && !in_err;
          st_d     = in_eof ? ST_IDLE : ST_DROP;
        end
      end else begin
        unique case (st_q)
          ST_ADDR_HI: begin
            pend_d = 1'b0;
            if (hit) begin
              q_push = 1'b1;
              st_d   = in_eof ? ST_IDLE : ST_PASS;
            end else begin
              q_drop   = 1'b1;
              miss_end = in_eof && !in_err;
              st_d     = in_eof ? ST_IDLE : ST_DROP;
            end
          end
          ST_PASS: begin
            q_push = 1'b1;
            if (in_eof) st_d = ST_IDLE;
          end
          ST_DROP: begin
            if (in_eof) begin
              miss_end = !in_err;
              st_d     = ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    wtag.sof = in_sof;
    wtag.eof = in_eof;
    wtag.err = in_eof & in_err;
    q_wdata  = {in_data, wtag};
  end

  // A held, still undecided low byte may not leave the queue
  assign q_pop = (q_count != '0) && !((q_count == QCNT_W'(1)) && pend_q);

  // Rejected-frame counter: clear wins, increment saturates
  assign cnt_sat = &nomatch_cnt;
  assign cnt_en  = cnt_clr | (miss_end & ~cnt_sat);
  assign cnt_d   = cnt_clr ? '0 : nomatch_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nomatch_cnt <= '0;
    end else if (cnt_en) begin
      nomatch_cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int NUM_ADDR   = 4,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2,
  localparam int ADDR_W    = 2 * BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wide,
  input  logic [ADDR_W-1:0]          cfg_mask,
  input  logic [NUM_ADDR*ADDR_W-1:0] cfg_addr,
  input  logic                       in_valid,
  input  logic [BYTE_W-1:0]          in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic                       in_err,
  input  logic                       cnt_clr,
  output logic                       out_valid,
  output logic [BYTE_W-1:0]          out_data,
  output logic                       out_sof,
  output logic                       out_eof,
  output logic                       out_err,
  output logic [CNT_W-1:0]           nomatch_cnt
);

  localparam int QW     = BYTE_W + TAG_W;
  localparam int QCNT_W = $clog2(FIFO_DEPTH + 1);

  logic              rst_n_s;
  logic [ADDR_W-1:0] addr_asm;
  logic              hit;
  logic              q_push, q_drop, q_pop;
  logic [QW-1:0]     q_wdata, q_rdata;
  logic [QCNT_W-1:0] q_count;
  byte_tag_t         rtag;

  hdlc_af_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  hdlc_af_match #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_match (
    .addr    (addr_asm),
    .mask    (cfg_mask),
    .table_i (cfg_addr),
    .hit     (hit)
  );

  hdlc_af_ctl #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .QCNT_W(QCNT_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .cfg_wide    (cfg_wide),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_err      (in_err),
    .hit         (hit),
    .cnt_clr     (cnt_clr),
    .q_count     (q_count),
    .addr_asm    (addr_asm),
    .q_push      (q_push),
    .q_drop      (q_drop),
    .q_wdata     (q_wdata),
    .q_pop       (q_pop),
    .nomatch_cnt (nomatch_cnt)
  );

  hdlc_af_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (q_push),
    .drop_tail (q_drop),
    .wdata     (q_wdata),
    .pop       (q_pop),
    .rdata     (q_rdata),
    .count     (q_count)
  );

  assign rtag = byte_tag_t'(q_rdata[TAG_W-1:0]);

  // Registered output stage
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= q_pop;
      out_sof   <= q_pop & rtag.sof;
      out_eof   <= q_pop & rtag.eof;
      out_err   <= q_pop & rtag.err;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_data <= '0;
    end else if (q_pop) begin
      out_data <= q_rdata[QW-1:TAG_W];
    end
  end

endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             in_err,
  input logic             cnt_clr,
  input logic             out_valid,
  input logic             out_eof,
  input logic             out_err,
  input logic [CNT_W-1:0] nomatch_cnt
);

  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (nomatch_cnt == '0));

  // R11
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&nomatch_cnt) && !cnt_clr) |=> (&nomatch_cnt));

  // R8
  err_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && in_err && !cnt_clr) |=> $stable(nomatch_cnt));

  // R12
  cnt_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(in_valid && in_eof)) |=> $stable(nomatch_cnt));

  // R7
  cnt_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(&nomatch_cnt)) |=>
      ((nomatch_cnt == $past(nomatch_cnt)) ||
       (nomatch_cnt == $past(nomatch_cnt) + CNT_W'(1))));

  // R6
  err_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_eof));

endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eof      (in_eof),
  .in_err      (in_err),
  .cnt_clr     (cnt_clr),
  .out_valid   (out_valid),
  .out_eof     (out_eof),
  .out_err     (out_err),
  .nomatch_cnt (nomatch_cnt)
);

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ADDR   = 4;
  localparam int FIFO_DEPTH = 4;
  localparam int CNT_W      = 4;
  localparam int AW         = 16;

  logic                   clk, rst_n;
  logic                   cfg_wide;
  logic [AW-1:0]          cfg_mask;
  logic [NUM_ADDR*AW-1:0] cfg_addr;
  logic                   in_valid, in_sof, in_eof, in_err, cnt_clr;
  logic [7:0]             in_data;
  logic                   out_valid, out_sof, out_eof, out_err;
  logic [7:0]             out_data;
  logic [CNT_W-1:0]       nomatch_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] tx [0:15];
  logic [7:0] rx_data [0:255];
  logic [2:0] rx_tag  [0:255];
  int         rx_n = 0;

  hdlc_addr_filter #(
    .NUM_ADDR(NUM_ADDR), .BYTE_W(8), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_mask(cfg_mask),
    .cfg_addr(cfg_addr), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .cnt_clr(cnt_clr),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_err(out_err), .nomatch_cnt(nomatch_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid && rx_n < 256) begin
      rx_data[rx_n] <= out_data;
      rx_tag[rx_n]  <= {out_sof, out_eof, out_err};
      rx_n          <= rx_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_table(input logic [15:0] a0, input logic [15:0] a1,
                           input logic [15:0] a2, input logic [15:0] a3);
    cfg_addr = {a3, a2, a1, a0};
  endtask

  // Drives tx[0..len-1] as one frame; caller stands at a negedge
  task automatic send(input int len, input bit err, input bit clr_last);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = tx[i];
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_err   = err && (i == len - 1);
      cnt_clr  = clr_last && (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    cnt_clr  = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Compares the bytes collected since 'base' with tx[0..len-1]
  task automatic expect_frame(input string req, input int base, input int len,
                              input bit err);
    int got = rx_n - base;
    chk(got == len, req, "forwarded byte count", got, len);
    if (got == len) begin
      for (int i = 0; i < len; i++) begin
        logic [2:0] et = {i == 0, i == len - 1, err && (i == len - 1)};
        chk(rx_data[base+i] == tx[i], req, "byte value", rx_data[base+i], tx[i]);
        chk(rx_tag[base+i] == et, req, "sof/eof/err tags", rx_tag[base+i], et);
      end
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R6", "out_valid after reset", out_valid, 0);
    chk(nomatch_cnt == '0, "R7", "counter after reset", nomatch_cnt, 0);
  endtask

  task automatic t_entries();  // R1: every slot can hit
    int base;
    cfg_wide = 1'b1; cfg_mask = 16'hFFFF;
    set_table(16'h1122, 16'h3344, 16'h5566, 16'h7788);
    for (int g = 0; g < NUM_ADDR; g++) begin
      logic [15:0] a = cfg_addr[g*AW +: AW];
      base = rx_n;
      tx[0] = a[7:0]; tx[1] = a[15:8]; tx[2] = 8'(8'h30 + g);
      send(3, 1'b0, 1'b0); settle();
      expect_frame("R1", base, 3, 1'b0);
    end
  endtask

  task automatic t_wide_unicast();  // R3, R6
    int base = rx_n;
    set_table(16'hAA68, 16'hFFFF, 16'hAA68, 16'hAA68);
    tx[0] = 8'h68; tx[1] = 8'hAA; tx[2] = 8'h44; tx[3] = 8'h12;
    send(4, 1'b0, 1'b0); settle();
    expect_frame("R3", base, 4, 1'b0);
  endtask

  task automatic t_broadcast();  // R5
    int base = rx_n;
    tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h44;
    send(3, 1'b0, 1'b0); settle();
    expect_frame("R5", base, 3, 1'b0);
  endtask

  task automatic t_order_miss();  // R3, R7
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    tx[0] = 8'hAA; tx[1] = 8'h68; tx[2] = 8'h44;
    send(3, 1'b0, 1'b0); settle();
    chk(rx_n == base, "R3", "reversed address forwarded bytes", rx_n - base, 0);
    chk(int'(nomatch_cnt) == c0 + 1, "R7", "counter after miss", nomatch_cnt, c0 + 1);
  endtask

  task automatic t_errors();  // R8, R6
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    tx[0] = 8'h68; tx[1] = 8'hAB; tx[2] = 8'h44;
    send(3, 1'b1, 1'b0); settle();
    chk(rx_n == base, "R8", "errored miss forwarded bytes", rx_n - base, 0);
    chk(int'(nomatch_cnt) == c0, "R8", "counter after errored miss", nomatch_cnt, c0);
    tx[1] = 8'hAA; tx[2] = 8'h99;
    send(3, 1'b1, 1'b0); settle();
    expect_frame("R6", base, 3, 1'b1);
    chk(int'(nomatch_cnt) == c0, "R8", "counter after errored hit", nomatch_cnt, c0);
  endtask

  task automatic t_mask();  // R2
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    cfg_mask = 16'hFFF0;
    set_table(16'hAA60, 16'h0000, 16'h0000, 16'h0000);
    tx[0] = 8'h6B; tx[1] = 8'hAA; tx[2] = 8'h01;
    send(3, 1'b0, 1'b0); settle();
    expect_frame("R2", base, 3, 1'b0);
    base = rx_n;
    tx[1] = 8'hAB;
    send(3, 1'b0, 1'b0); settle();
    chk(rx_n == base, "R2", "compared bit differs, forwarded", rx_n - base, 0);
    chk(int'(nomatch_cnt) == c0 + 1, "R2", "counter after masked miss", nomatch_cnt, c0 + 1);
  endtask

  task automatic t_narrow();  // R4
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    cfg_wide = 1'b0; cfg_mask = 16'h00FF;
    set_table(16'h1255, 16'h3455, 16'h5655, 16'h7855);
    tx[0] = 8'h55; tx[1] = 8'h77;
    send(2, 1'b0, 1'b0); settle();
    expect_frame("R4", base, 2, 1'b0);
    base = rx_n;
    send(1, 1'b0, 1'b0); settle();
    expect_frame("R4", base, 1, 1'b0);
    base = rx_n;
    tx[0] = 8'h56;
    send(2, 1'b0, 1'b0); settle();
    chk(rx_n == base, "R4", "single-byte miss forwarded", rx_n - base, 0);
    chk(int'(nomatch_cnt) == c0 + 1, "R4", "counter after single-byte miss", nomatch_cnt, c0 + 1);
    cfg_wide = 1'b1; cfg_mask = 16'hFFFF;
    set_table(16'hAA68, 16'hFFFF, 16'hAA68, 16'hAA68);
  endtask

  task automatic t_short();  // R9
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    tx[0] = 8'h68;
    send(1, 1'b0, 1'b0); settle();
    chk(rx_n == base, "R9", "one-byte frame forwarded", rx_n - base, 0);
    chk(int'(nomatch_cnt) == c0 + 1, "R9", "counter after short frame", nomatch_cnt, c0 + 1);
    send(1, 1'b1, 1'b0); settle();
    chk(int'(nomatch_cnt) == c0 + 1, "R9", "counter after errored short frame", nomatch_cnt, c0 + 1);
  endtask

  task automatic t_hold();  // R10
    int base = rx_n;
    in_valid = 1'b1; in_data = 8'h68; in_sof = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (8) @(negedge clk);
    chk(rx_n == base, "R10", "bytes out before second address byte", rx_n - base, 0);
    tx[0] = 8'hAA; tx[1] = 8'h5A;
    in_valid = 1'b1; in_data = tx[0]; @(negedge clk);
    in_data = tx[1]; in_eof = 1'b1; @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    settle();
    tx[2] = tx[1]; tx[1] = tx[0]; tx[0] = 8'h68;
    expect_frame("R10", base, 3, 1'b0);
  endtask

  task automatic t_back_to_back();  // R6, R7
    int base = rx_n;
    int c0 = int'(nomatch_cnt);
    logic [7:0] exp_b [0:6];
    tx[0] = 8'h68; tx[1] = 8'hAA; tx[2] = 8'h01; tx[3] = 8'h02;
    for (int i = 0; i < 4; i++) exp_b[i] = tx[i];
    send(4, 1'b0, 1'b0);
    tx[0] = 8'h68; tx[1] = 8'hAB; tx[2] = 8'h03;
    send(3, 1'b0, 1'b0);
    tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h04;
    for (int i = 0; i < 3; i++) exp_b[4+i] = tx[i];
    send(3, 1'b0, 1'b0);
    settle();
    chk(rx_n - base == 7, "R6", "back-to-back forwarded count", rx_n - base, 7);
    if (rx_n - base == 7) begin
      for (int i = 0; i < 7; i++)
        chk(rx_data[base+i] == exp_b[i], "R6", "back-to-back byte", rx_data[base+i], exp_b[i]);
      chk(rx_tag[base+3] == 3'b010 && rx_tag[base+4] == 3'b100, "R6",
          "frame boundary tags", {rx_tag[base+3], rx_tag[base+4]}, 9'b010_100);
    end
    chk(int'(nomatch_cnt) == c0 + 1, "R7", "counter after mixed burst", nomatch_cnt, c0 + 1);
  endtask

  task automatic t_counter();  // R11, R12
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0; @(negedge clk);
    chk(nomatch_cnt == '0, "R12", "counter after clear", nomatch_cnt, 0);
    tx[0] = 8'h11; tx[1] = 8'h22;
    for (int k = 0; k < 15; k++) send(2, 1'b0, 1'b0);
    settle();
    chk(nomatch_cnt == 4'hF, "R11", "counter at all-ones", nomatch_cnt, 15);
    send(2, 1'b0, 1'b0); settle();
    chk(nomatch_cnt == 4'hF, "R11", "counter held at saturation", nomatch_cnt, 15);
    send(2, 1'b0, 1'b1); settle();
    chk(nomatch_cnt == '0, "R12", "clear beats same-cycle increment", nomatch_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    in_err = 1'b0; cnt_clr = 1'b0; cfg_wide = 1'b1; cfg_mask = 16'hFFFF;
    cfg_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_entries();
    t_wide_unicast();
    t_broadcast();
    t_order_miss();
    t_errors();
    t_mask();
    set_table(16'hAA68, 16'hFFFF, 16'hAA68, 16'hAA68);
    cfg_mask = 16'hFFFF;
    t_narrow();
    t_short();
    t_hold();
    t_back_to_back();
    t_counter();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule